// File: doc/BRIEF.md
# PHY Capability Strap and Renegotiation Controller

This controller works beside one MII port and swaps link settings with the attached PHY over the MII data pins while no frames are moving. At the moment the link comes up, it reads the duplex, pause and speed results the PHY left on the receive nibble. While the link is down, it shows the capabilities it wants on the transmit nibble. It also drives an active-low renegotiate line that asks the PHY to start a new negotiation.

The link input is asynchronous and passes through a flop synchronizer. The receive pins pass through a matching pipeline that is one stage longer. When the synchronized link rises, the controller looks at what the receive pins carried in the cycle just before the rise. It keeps that sample only if receive-valid and receive-error were both low in that cycle. A rising edge on the negotiate control bit starts a renegotiate request. The request ends once the synchronized link has gone low. The line is also held asserted until the init-done control bit is set.

Top module: `phy_strap_ctl`

## Requirements
- R1: The status bits update in the third clock edge after the raw link input rises. They take the receive nibble sampled in the cycle just before the raw link rose, and only if receive-valid and receive-error were both low in that cycle.
- R2: The captured receive bit 0 sets st_full (1 = full duplex). Bit 1 sets st_pause (1 = pause supported). Bit 2 sets st_100 (1 = 100 Mbit/s, 0 = 10 Mbit/s). Receive bit 3 has no effect.
- R3: If receive-valid or receive-error was high in the sample cycle, a link rise leaves all three status bits at their previous values.
- R4: Between link rising edges, the status bits do not change, whatever the receive pins do.
- R5: When tx_en, tx_er and the synchronized link are all low, txd_out advertises as follows: bit 0 = !cfg_half, bit 1 = !cfg_nopause, bit 2 = !cfg_10m, bit 3 = 0.
- R6: When the advertise condition of R5 is not met, txd_out equals txd_in.
- R7: A 0-to-1 change of cfg_neg drives reneg_n low from the next clock edge. It stays low until the edge after the synchronized link is seen low.
- R8: If the link is already low when cfg_neg rises, reneg_n is low for exactly one cycle.
- R9: While cfg_init_done is 0, reneg_n is low regardless of link state.
- R10: After reset, all status bits are 0 and no renegotiate request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_in | input | 1 | Raw link status from the PHY |
| rxd | input | 4 | Receive data nibble |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error |
| cfg_half | input | 1 | Request half duplex only |
| cfg_nopause | input | 1 | Request no pause support |
| cfg_10m | input | 1 | Request 10 Mbit/s only |
| cfg_neg | input | 1 | Renegotiate request, acts on its rising edge |
| cfg_init_done | input | 1 | Initialisation complete |
| txd_in | input | 4 | Normal transmit data nibble |
| tx_en | input | 1 | Transmit enable |
| tx_er | input | 1 | Transmit error |
| st_full | output | 1 | Captured full-duplex result |
| st_pause | output | 1 | Captured pause result |
| st_100 | output | 1 | Captured 100 Mbit/s result |
| txd_out | output | 4 | Transmit nibble toward the PHY |
| reneg_n | output | 1 | Active-low renegotiate request |

## Verification
The hardest thing to reach from the ports is the capture window. It is exactly one cycle wide and sits several synchronizer stages behind the raw link input. The bench drives each receive pattern steadily while the link is low, then raises the link and scrambles the receive pins in the same cycle. A capture taken in the wrong cycle therefore picks up the scrambled value. The renegotiate release is handled the same way: the bench drops the link at a known cycle and samples reneg_n at each edge of the synchronizer delay.

// File: rtl/phy_strap_ctl.sv
module phy_strap_ctl #(
  parameter int SYNC_STAGES = 2,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_in,
  input  logic [NIB_W-1:0] rxd,
  input  logic             rx_dv,
  input  logic             rx_er,
  input  logic             cfg_half,
  input  logic             cfg_nopause,
  input  logic             cfg_10m,
  input  logic             cfg_neg,
  input  logic             cfg_init_done,
  input  logic [NIB_W-1:0] txd_in,
  input  logic             tx_en,
  input  logic             tx_er,
  output logic             st_full,
  output logic             st_pause,
  output logic             st_100,
  output logic [NIB_W-1:0] txd_out,
  output logic             reneg_n
);

  localparam int PIPE_W = NIB_W + 2;
  localparam int PIPE_D = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0] link_sr;
  logic                   link_q, link_prev, link_rise;
  logic [PIPE_W-1:0]      rx_pipe [PIPE_D];
  logic [PIPE_W-1:0]      rx_old;
  logic                   neg_prev, neg_rise, hold;
  logic                   adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_sr   <= '0;
      link_prev <= 1'b0;
    end else begin
      link_sr   <= {link_sr[SYNC_STAGES-2:0], link_in};
      link_prev <= link_q;
    end
  end

  assign link_q    = link_sr[SYNC_STAGES-1];
  assign link_rise = link_q & ~link_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PIPE_D; i++) rx_pipe[i] <= '0;
    end else begin
      rx_pipe[0] <= {rx_er, rx_dv, rxd};
      for (int i = 1; i < PIPE_D; i++) rx_pipe[i] <= rx_pipe[i-1];
    end
  end

  assign rx_old = rx_pipe[PIPE_D-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_full  <= 1'b0;
      st_pause <= 1'b0;
      st_100   <= 1'b0;
    end else if (link_rise && !rx_old[NIB_W] && !rx_old[NIB_W+1]) begin
      st_full  <= rx_old[0];
      st_pause <= rx_old[1];
      st_100   <= rx_old[2];
    end
  end

  assign adv     = !tx_en && !tx_er && !link_q;
  assign txd_out = adv ? {{(NIB_W-3){1'b0}}, ~cfg_10m, ~cfg_nopause, ~cfg_half} : txd_in;

  assign neg_rise = cfg_neg & ~neg_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_prev <= 1'b0;
      hold     <= 1'b0;
    end else begin
      neg_prev <= cfg_neg;
      if (neg_rise)             hold <= 1'b1;
      else if (hold && !link_q) hold <= 1'b0;
    end
  end

  assign reneg_n = cfg_init_done & ~hold;

endmodule

module phy_strap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       link_q,
  input logic       link_rise,
  input logic       cfg_neg,
  input logic       cfg_init_done,
  input logic       tx_en,
  input logic [3:0] txd_in,
  input logic [3:0] txd_out,
  input logic       st_full,
  input logic       st_pause,
  input logic       st_100,
  input logic       reneg_n
);
  // R4
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_rise |=> $stable({st_full, st_pause, st_100}));
  // R6
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> txd_out == txd_in);
  // R7
  neg_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_neg) |=> !reneg_n);
  // R9
  init_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_init_done |-> !reneg_n);
  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(reneg_n) && cfg_init_done && $past(cfg_init_done) && !$rose(cfg_neg)) |-> !$past(link_q));
endmodule

bind phy_strap_ctl phy_strap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .link_q(link_q), .link_rise(link_rise),
  .cfg_neg(cfg_neg), .cfg_init_done(cfg_init_done), .tx_en(tx_en),
  .txd_in(txd_in), .txd_out(txd_out), .st_full(st_full),
  .st_pause(st_pause), .st_100(st_100), .reneg_n(reneg_n)
);

// File: tb/tb_phy_strap_ctl.sv
module tb_phy_strap_ctl;
  logic clk = 0, rst_n = 0;
  logic link_in = 0, rx_dv = 0, rx_er = 0;
  logic [3:0] rxd = 0, txd_in = 0, txd_out;
  logic cfg_half = 0, cfg_nopause = 0, cfg_10m = 0, cfg_neg = 0, cfg_init_done = 0;
  logic tx_en = 0, tx_er = 0;
  logic st_full, st_pause, st_100, reneg_n;
  int errors = 0, checks = 0;
  logic [2:0] last;

  always #2 clk = ~clk;

  phy_strap_ctl dut (.*);

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic link_up(logic [3:0] p, logic dv, logic er);
    @(negedge clk);
    link_in = 0; rxd = p; rx_dv = dv; rx_er = er;
    nclk(4);
    link_in = 1; rxd = ~p; rx_dv = ~dv; rx_er = ~er;
    nclk(3);
  endtask

  task automatic link_down();
    @(negedge clk);
    link_in = 0; rx_dv = 0; rx_er = 0;
    nclk(4);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    nclk(3);
    // R10 reset state
    chk("R10", {1'b0, st_100, st_pause, st_full}, 4'h0);
    // R9 init not done
    chk("R9", {3'b0, reneg_n}, 4'h0);
    rst_n = 1;
    nclk(2);
    chk("R9", {3'b0, reneg_n}, 4'h0);
    link_in = 1; nclk(4);
    chk("R9", {3'b0, reneg_n}, 4'h0);
    link_in = 0; nclk(4);
    cfg_init_done = 1; #1;
    chk("R10", {3'b0, reneg_n}, 4'h1);

    // R1 R2 capture sweep, bit 3 ignored
    for (int p = 0; p < 16; p++) begin
      link_up(4'(p), 0, 0);
      chk("R1 R2", {1'b0, st_100, st_pause, st_full}, {1'b0, 3'(p)});
      last = 3'(p);
      // R4 scramble receive pins while link up
      for (int k = 0; k < 4; k++) begin
        rxd = 4'(k * 5 + p); rx_dv = k[0]; rx_er = k[1];
        nclk(1);
      end
      chk("R4", {1'b0, st_100, st_pause, st_full}, {1'b0, last});
      link_down();
      chk("R4", {1'b0, st_100, st_pause, st_full}, {1'b0, last});
    end

    // R3 capture blocked by valid or error
    for (int m = 1; m < 4; m++) begin
      link_up(4'h7, 0, 0); link_down();
      link_up(4'h0, m[0], m[1]);
      chk("R3", {1'b0, st_100, st_pause, st_full}, 4'h7);
      link_down();
    end

    // R1 timing: not yet updated after two edges
    link_up(4'h0, 0, 0); link_down();
    @(negedge clk); rxd = 4'h5; nclk(4);
    link_in = 1; rxd = 4'h2; nclk(2);
    chk("R1", {1'b0, st_100, st_pause, st_full}, 4'h0);
    nclk(1);
    chk("R1", {1'b0, st_100, st_pause, st_full}, 4'h5);
    link_down();

    // R5 advertise sweep
    for (int c = 0; c < 8; c++) begin
      cfg_half = c[0]; cfg_nopause = c[1]; cfg_10m = c[2];
      txd_in = 4'(15 - c); tx_en = 0; tx_er = 0; #1;
      chk("R5", txd_out, {1'b0, ~c[2], ~c[1], ~c[0]});
      // R6 tx_en or tx_er blocks advertise
      tx_en = 1; #1;
      chk("R6", txd_out, 4'(15 - c));
      tx_en = 0; tx_er = 1; #1;
      chk("R6", txd_out, 4'(15 - c));
      tx_er = 0;
      nclk(1);
    end
    // R6 link up passes through
    cfg_half = 0; cfg_nopause = 0; cfg_10m = 0;
    link_in = 1; nclk(3);
    for (int d = 0; d < 16; d++) begin
      txd_in = 4'(d); #1;
      chk("R6", txd_out, 4'(d));
    end
    link_in = 0; nclk(3);

    // R8 link already low: exactly one cycle
    @(negedge clk); cfg_neg = 1;
    nclk(1);
    chk("R8", {3'b0, reneg_n}, 4'h0);
    nclk(1);
    chk("R8", {3'b0, reneg_n}, 4'h1);
    cfg_neg = 0; nclk(2);
    chk("R8", {3'b0, reneg_n}, 4'h1);

    // R7 link up: held until synced link low
    link_in = 1; nclk(4);
    cfg_neg = 1;
    nclk(1);
    chk("R7", {3'b0, reneg_n}, 4'h0);
    nclk(5);
    chk("R7", {3'b0, reneg_n}, 4'h0);
    link_in = 0;
    nclk(2);
    chk("R7", {3'b0, reneg_n}, 4'h0);
    nclk(1);
    chk("R7", {3'b0, reneg_n}, 4'h1);
    nclk(3);
    chk("R7", {3'b0, reneg_n}, 4'h1);
    cfg_neg = 0; nclk(2);

    // R9 init_done cleared overrides everything
    cfg_init_done = 0; #1;
    chk("R9", {3'b0, reneg_n}, 4'h0);
    cfg_init_done = 1; #1;
    chk("R9", {3'b0, reneg_n}, 4'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule